// File: doc/BRIEF.md
# Audio Transmit Queue Register Front-End

This block sits between a 32-bit memory-mapped control bus and an external audio serializer. Software writes sample words into a deep transmit queue through any of four data registers, configures the serializer through a configuration register, and services an interrupt that tells it when the queue is running low or has run dry. The serializer drains the queue through a simple pop port that always presents the oldest word.

Two live conditions are watched every cycle: the queue being empty (underrun) and the fill being below a programmable trigger threshold (low level). The threshold is the queue depth shifted right by a 4-bit level code held in the configuration register. Each condition sets a latched status bit. Software clears a bit by writing 1 to it, and the bit sets again on the next cycle if its condition still holds. A data write that finds the queue full is dropped and recorded in a sticky overflow status bit, which never raises the interrupt.

The queue depth is `2**DEPTH_LOG2` words and the version constant is a parameter.

Top module: `txq_front`

## Requirements
- R1: Register word offsets are 0x00 version (read-only, returns parameter VERSION), 0x04 configuration, 0x08 interrupt mask, 0x0C status and 0x10, 0x14, 0x18, 0x1C data. A read returns its word on `rdata` in the cycle after the read strobe. Data offsets read as zero. An access whose address bits 1:0 are not zero touches no register.
- R2: Configuration bits: 0 transmit enable, 1 interrupt enable, 2 left-first, 15:8 clock ratio, 21:16 sample resolution, 27:24 level code, 31:28 channel select. Bits 7:3 and 23:22 read as zero, and every field drives its output port directly.
- R3: Each write to any data offset pushes the full 32-bit write word into the queue. `ser_avail` is high while the queue holds a word, `ser_data` shows the oldest word, and a `ser_pop` pulse removes it, so words leave in write order.
- R4: A data write while the queue holds `2**DEPTH_LOG2` words is dropped, leaves the contents unchanged and sets status bit 2 (overflow). That bit stays set until 1 is written to it, and it never raises `irq`.
- R5: Status bit 0 (underrun) sets in the cycle after the queue is seen empty and stays set after the queue refills, until it is cleared.
- R6: Status bit 1 (low level) sets in the cycle after the fill is seen below `2**DEPTH_LOG2 >> L`, where L is configuration bits 27:24 (0 to 15). It stays set until it is cleared.
- R7: Writing 1 to a status bit clears it. The bit sets again one cycle later if its condition still holds. Writing 0 to a status bit has no effect.
- R8: `irq` is high exactly when configuration bit 1 is set and status bits 1:0 ANDed with mask bits 1:0 (same positions) are nonzero. Mask bits 31:2 read as zero.
- R9: During reset, configuration, mask and status are zero, the queue is empty and `irq` is low.
- R10: A `ser_pop` while the queue is empty is ignored and leaves the queue order intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ser_pop | input | 1 | Serializer consumes the head word |
| ser_data | output | 32 | Head word of the queue |
| ser_avail | output | 1 | Queue holds at least one word |
| irq | output | 1 | Interrupt request |
| tx_enable | output | 1 | Transmit enable field |
| left_first | output | 1 | Left-first field |
| clk_ratio | output | 8 | Clock ratio field |
| sample_res | output | 6 | Sample resolution field |
| chan_sel | output | 4 | Channel select field |

## Verification
The bench builds the block with `DEPTH_LOG2 = 5`, a 32-word queue, so every fill value from empty to full can be reached. At each fill it sweeps all sixteen level codes against the threshold `32 >> L`. Codes above 5 bring in the zero-threshold case, where the low-level bit can never set, and code 0 brings in the case where only a full queue is not low. The small depth also lets the bench drive overflow, pop on empty, and the sticky and re-setting behaviour of each status bit within a few thousand cycles.

// File: rtl/txq_pkg.sv
`timescale 1ns/1ps
package txq_pkg;
   localparam int unsigned REG_W    = 32;
   localparam int unsigned NUM_DATA = 4;

   // word indices (byte offset >> 2)
   localparam int unsigned W_VERSION = 0;
   localparam int unsigned W_CONFIG  = 1;
   localparam int unsigned W_MASK    = 2;
   localparam int unsigned W_STATUS  = 3;
   localparam int unsigned W_DATA0   = 4;

   // status / mask bit positions
   localparam int unsigned ST_UNDER = 0;
   localparam int unsigned ST_LOW   = 1;
   localparam int unsigned ST_OVF   = 2;
   localparam int unsigned NUM_SRC  = 2;
   localparam int unsigned NUM_ST   = 3;

   typedef struct packed {
      logic [3:0] chan;
      logic [3:0] level;
      logic [5:0] res;
      logic [7:0] ratio;
      logic       left;
      logic       irq_en;
      logic       tx_en;
   } cfg_t;

   function automatic logic [REG_W-1:0] cfg_pack(input cfg_t c);
      logic [REG_W-1:0] w;
      w        = '0;
      w[0]     = c.tx_en;
      w[1]     = c.irq_en;
      w[2]     = c.left;
      w[15:8]  = c.ratio;
      w[21:16] = c.res;
      w[27:24] = c.level;
      w[31:28] = c.chan;
      return w;
   endfunction
endpackage

// File: rtl/txq_fifo.sv
`timescale 1ns/1ps
module txq_fifo #(
   parameter int unsigned DW = 32,
   parameter int unsigned AW = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic [DW-1:0] head,
   output logic          avail,
   output logic [AW:0]   fill,
   output logic          dropped
);
   localparam int unsigned DEPTH = 1 << AW;
   localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          full, do_push, do_pop;

   assign full    = (fill == FULL_CNT);
   assign avail   = (fill != '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & avail;
   assign dropped = push & full;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + 1'b1;
         if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
         case ({do_push, do_pop})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end

   AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= FULL_CNT);                                            // R4
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> $stable(fill));                    // R4
   AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !avail && !push) |=> (fill == '0));                   // R10
endmodule

// File: rtl/txq_status.sv
`timescale 1ns/1ps
module txq_status
   import txq_pkg::*;
#(
   parameter int unsigned AW = 13
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [AW:0]        fill,
   input  logic [3:0]         level_code,
   input  logic               irq_en,
   input  logic [NUM_SRC-1:0] mask,
   input  logic [NUM_ST-1:0]  clr,
   input  logic               drop,
   output logic [NUM_ST-1:0]  st,
   output logic               irq
);
   localparam int unsigned CW = AW + 1;
   localparam logic [CW-1:0] DEPTH_CNT = CW'(1) << AW;

   logic [CW-1:0]      thresh;
   logic [NUM_ST-1:0]  cond;

   assign thresh = DEPTH_CNT >> level_code;

   // live conditions feeding the latched bits
   assign cond[ST_UNDER] = (fill == '0);
   assign cond[ST_LOW]   = (fill < thresh);
   assign cond[ST_OVF]   = drop;

   for (genvar b = 0; b < NUM_ST; b++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) st[b] <= 1'b0;
         else        st[b] <= (st[b] & ~clr[b]) | cond[b];
      end
   end

   assign irq = irq_en & (|(st[NUM_SRC-1:0] & mask));

   AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill == '0) && !clr[ST_UNDER]) |=> st[ST_UNDER]);          // R5
   AST_LEVEL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ((fill < (DEPTH_CNT >> level_code)) && !clr[ST_LOW]) |=> st[ST_LOW]); // R6
   AST_W1C_UNDER: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[ST_UNDER] && (fill != '0)) |=> !st[ST_UNDER]);          // R7
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (st[ST_OVF] && !clr[ST_OVF]) |=> st[ST_OVF]);                 // R4
endmodule

// File: rtl/txq_csr.sv
`timescale 1ns/1ps
module txq_csr
   import txq_pkg::*;
#(
   parameter int unsigned      ADDR_W  = 5,
   parameter logic [REG_W-1:0] VERSION = 32'h0001_0200
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [REG_W-1:0]   bus_wdata,
   output logic [REG_W-1:0]   bus_rdata,
   input  logic [NUM_ST-1:0]  st,
   output cfg_t               cfg,
   output logic [NUM_SRC-1:0] mask,
   output logic [NUM_ST-1:0]  clr,
   output logic               push
);
   localparam int unsigned WW = ADDR_W - 2;

   logic [WW-1:0]       word;
   logic                aligned;
   logic                wr_cfg, wr_mask, wr_st;
   logic [NUM_DATA-1:0] data_hit;
   logic [REG_W-1:0]    rd_mux;

   assign word    = bus_addr[ADDR_W-1:2];
   assign aligned = (bus_addr[1:0] == 2'b00);
   assign wr_cfg  = bus_wr & aligned & (word == WW'(W_CONFIG));
   assign wr_mask = bus_wr & aligned & (word == WW'(W_MASK));
   assign wr_st   = bus_wr & aligned & (word == WW'(W_STATUS));

   for (genvar d = 0; d < NUM_DATA; d++) begin : g_data
      assign data_hit[d] = bus_wr & aligned & (word == WW'(W_DATA0 + d));
   end
   assign push = |data_hit;
   assign clr  = wr_st ? bus_wdata[NUM_ST-1:0] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg  <= '0;
         mask <= '0;
      end else begin
         if (wr_cfg) begin
            cfg.tx_en  <= bus_wdata[0];
            cfg.irq_en <= bus_wdata[1];
            cfg.left   <= bus_wdata[2];
            cfg.ratio  <= bus_wdata[15:8];
            cfg.res    <= bus_wdata[21:16];
            cfg.level  <= bus_wdata[27:24];
            cfg.chan   <= bus_wdata[31:28];
         end
         if (wr_mask) mask <= bus_wdata[NUM_SRC-1:0];
      end
   end

   always_comb begin
      rd_mux = '0;
      if (aligned) begin
         if (word == WW'(W_VERSION))     rd_mux = VERSION;
         else if (word == WW'(W_CONFIG)) rd_mux = cfg_pack(cfg);
         else if (word == WW'(W_MASK))   rd_mux = REG_W'(mask);
         else if (word == WW'(W_STATUS)) rd_mux = REG_W'(st);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cfg |=> $stable(cfg));                                    // R2
   AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({wr_cfg, wr_mask, wr_st, push}));                    // R1
endmodule

// File: rtl/txq_front.sv
`timescale 1ns/1ps
module txq_front
   import txq_pkg::*;
#(
   parameter int unsigned      ADDR_W     = 5,
   parameter int unsigned      DEPTH_LOG2 = 11,
   parameter logic [REG_W-1:0] VERSION    = 32'h0001_0200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              ser_pop,
   output logic [31:0]       ser_data,
   output logic              ser_avail,
   output logic              irq,
   output logic              tx_enable,
   output logic              left_first,
   output logic [7:0]        clk_ratio,
   output logic [5:0]        sample_res,
   output logic [3:0]        chan_sel
);
   if (ADDR_W < 5) begin : g_bad_addr
      $error("txq_front: ADDR_W must cover the 0x00-0x1C register window");
   end
   if (DEPTH_LOG2 < 2 || DEPTH_LOG2 > 16) begin : g_bad_depth
      $error("txq_front: DEPTH_LOG2 out of supported range");
   end

   cfg_t               cfg;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_ST-1:0]  clr, st;
   logic               push, dropped;
   logic [DEPTH_LOG2:0] fill;

   txq_csr #(.ADDR_W(ADDR_W), .VERSION(VERSION)) u_csr (
      .clk(clk), .rst_n(rst_n),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .st(st), .cfg(cfg), .mask(mask), .clr(clr), .push(push)
   );

   txq_fifo #(.DW(REG_W), .AW(DEPTH_LOG2)) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .push(push), .push_data(bus_wdata), .pop(ser_pop),
      .head(ser_data), .avail(ser_avail), .fill(fill), .dropped(dropped)
   );

   txq_status #(.AW(DEPTH_LOG2)) u_status (
      .clk(clk), .rst_n(rst_n),
      .fill(fill), .level_code(cfg.level), .irq_en(cfg.irq_en),
      .mask(mask), .clr(clr), .drop(dropped), .st(st), .irq(irq)
   );

   assign tx_enable  = cfg.tx_en;
   assign left_first = cfg.left;
   assign clk_ratio  = cfg.ratio;
   assign sample_res = cfg.res;
   assign chan_sel   = cfg.chan;

   AST_OVF_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (st[NUM_SRC-1:0] == '0) |-> !irq);                            // R8
endmodule

// File: tb/txq_front_bench.sv
`timescale 1ns/1ps
module txq_front_bench;
   localparam int DL = 5;
   localparam int DEPTH = 1 << DL;
   localparam logic [31:0] VER = 32'h0001_0200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ser_pop = 1'b0;
   logic [31:0] ser_data;
   logic        ser_avail, irq, tx_enable, left_first;
   logic [7:0]  clk_ratio;
   logic [5:0]  sample_res;
   logic [3:0]  chan_sel;

   int checks = 0;
   int fails  = 0;
   logic [31:0] rv;

   always #4 clk = ~clk; // 125 MHz

   txq_front #(.ADDR_W(5), .DEPTH_LOG2(DL), .VERSION(VER)) u_txq_front (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ser_pop(ser_pop), .ser_data(ser_data), .ser_avail(ser_avail),
      .irq(irq), .tx_enable(tx_enable), .left_first(left_first),
      .clk_ratio(clk_ratio), .sample_res(sample_res), .chan_sel(chan_sel)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic pop1();
      @(negedge clk); ser_pop = 1'b1;
      @(negedge clk); ser_pop = 1'b0;
   endtask

   function automatic logic [31:0] st_exp(input int f, input int lv);
      logic [31:0] e;
      e = '0;
      e[0] = (f == 0);
      e[1] = (f < (DEPTH >> lv));
      return e;
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      // R9: reset state while held in reset
      repeat (3) @(negedge clk);
      chk("R9 irq in reset", {31'b0, irq}, 32'h0);
      chk("R9 avail in reset", {31'b0, ser_avail}, 32'h0);
      chk("R9 cfg outputs in reset", {13'b0, tx_enable, left_first, clk_ratio, sample_res, chan_sel}, 32'h0);
      rst_n = 1'b1;
      rd(5'h04, rv); chk("R9 cfg after reset", rv, 32'h0);
      rd(5'h08, rv); chk("R9 mask after reset", rv, 32'h0);
      rd(5'h0C, rv); chk("R5 R6 status after reset", rv, 32'h3);

      // R1: version and data offsets read
      rd(5'h00, rv); chk("R1 version", rv, VER);
      for (int k = 0; k < 4; k++) begin
         rd(5'h10 + 5'(4*k), rv); chk("R1 data offset reads zero", rv, 32'h0);
      end

      // R5 R6 R7 R3: sweep every fill against every level code
      for (int f = 0; f <= DEPTH; f++) begin
         for (int lv = 0; lv < 16; lv++) begin
            wr(5'h04, 32'(lv) << 24);
            wr(5'h0C, 32'h3);
            rd(5'h0C, rv);
            chk($sformatf("R6 R5 fill=%0d level=%0d", f, lv), rv, st_exp(f, lv));
         end
         if (f < DEPTH) wr(5'h10 + 5'((f % 4) * 4), 32'hA500_0000 + 32'(f));
      end

      // R4: overflow drop and sticky flag
      wr(5'h10, 32'hDEAD_BEEF);
      rd(5'h0C, rv); chk("R4 overflow flag", rv, 32'h4);
      wr(5'h0C, 32'h4);
      rd(5'h0C, rv); chk("R4 overflow cleared", rv, 32'h0);

      // R3: order out of the pop port, dropped word absent
      for (int i = 0; i < DEPTH; i++) begin
         @(negedge clk);
         chk($sformatf("R3 head word %0d", i), ser_data, 32'hA500_0000 + 32'(i));
         chk("R3 avail while non-empty", {31'b0, ser_avail}, 32'h1);
         pop1();
      end
      @(negedge clk);
      chk("R3 empty after drain", {31'b0, ser_avail}, 32'h0);

      // R10: pop on empty ignored
      pop1();
      chk("R10 still empty", {31'b0, ser_avail}, 32'h0);
      wr(5'h14, 32'h1234_5678);
      @(negedge clk);
      chk("R10 head after empty pop", ser_data, 32'h1234_5678);
      pop1();
      chk("R10 drained", {31'b0, ser_avail}, 32'h0);

      // R5 R6 R7: sticky bits and clear semantics
      wr(5'h04, 32'h0100_0000);  // threshold 16
      wr(5'h0C, 32'h7);
      rd(5'h0C, rv); chk("R7 re-set while true", rv, 32'h3);
      for (int i = 0; i < 20; i++) wr(5'h18, 32'h100 + 32'(i));
      rd(5'h0C, rv); chk("R5 R6 sticky after condition gone", rv, 32'h3);
      wr(5'h0C, 32'h3);
      rd(5'h0C, rv); chk("R7 cleared stays clear", rv, 32'h0);
      for (int i = 0; i < 10; i++) pop1();
      rd(5'h0C, rv); chk("R6 low level at fill 10", rv, 32'h2);
      wr(5'h0C, 32'h0);
      rd(5'h0C, rv); chk("R7 write zero no effect", rv, 32'h2);

      // R8: interrupt gating
      wr(5'h08, 32'h0);
      @(negedge clk); chk("R8 mask zero", {31'b0, irq}, 32'h0);
      wr(5'h08, 32'h2);
      @(negedge clk); chk("R8 enable off", {31'b0, irq}, 32'h0);
      wr(5'h04, 32'h0100_0002);
      @(negedge clk); chk("R8 level source", {31'b0, irq}, 32'h1);
      wr(5'h08, 32'h1);
      @(negedge clk); chk("R8 masked source", {31'b0, irq}, 32'h0);
      wr(5'h08, 32'hFFFF_FFFF);
      @(negedge clk); chk("R8 all sources", {31'b0, irq}, 32'h1);
      rd(5'h08, rv); chk("R8 mask readback", rv, 32'h3);

      // R4: overflow never interrupts
      wr(5'h04, 32'h0500_0002);  // threshold 1
      wr(5'h0C, 32'h7);
      for (int i = 0; i < 22; i++) wr(5'h1C, 32'h200 + 32'(i));
      wr(5'h1C, 32'hBAD0_0000);
      rd(5'h0C, rv); chk("R4 overflow only", rv, 32'h4);
      chk("R4 overflow no irq", {31'b0, irq}, 32'h0);

      // R2: config fields
      wr(5'h04, 32'hFFFF_FFFF);
      rd(5'h04, rv); chk("R2 config all ones", rv, 32'hFF3F_FF07);
      chk("R2 fields all ones", {13'b0, tx_enable, left_first, clk_ratio, sample_res, chan_sel},
          {13'b0, 1'b1, 1'b1, 8'hFF, 6'h3F, 4'hF});
      wr(5'h04, 32'h5A2B_3C06);
      rd(5'h04, rv); chk("R2 config pattern", rv, 32'h5A2B_3C06);
      chk("R2 fields pattern", {13'b0, tx_enable, left_first, clk_ratio, sample_res, chan_sel},
          {13'b0, 1'b0, 1'b1, 8'h3C, 6'h2B, 4'h5});

      // R1: misaligned write ignored
      wr(5'h05, 32'h0);
      rd(5'h04, rv); chk("R1 misaligned write ignored", rv, 32'h5A2B_3C06);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule